// File: doc/BRIEF.md
# Branch Resolution and Target Unit

This block resolves one decoded branch per cycle. It takes the branch kind, its flag bits, the 5-bit branch-options field and the condition-bit selector. It also takes the displacement, the condition register, the count, link and target-address register values, the current instruction address and the address-width mode. From these it decides whether the branch is taken and forms the next instruction address. It also produces the write-backs for the count register and the link register.

Five kinds are supported:

| Kind | Code | Target |
|---|---|---|
| Unconditional immediate | 0 | Displacement |
| Conditional immediate | 1 | Displacement |
| Conditional to link | 2 | Link register |
| Conditional to count | 3 | Count register |
| Conditional to target | 4 | Target-address register |

Every result is registered: the outcome of an instruction offered with `in_valid` appears on the outputs one clock later. The count-register decrement and the link-register write are produced together in that same cycle. A register file fed from these outputs therefore updates both at one clock edge.

Top module: `br_resolve`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `out_valid`, `taken`, `ctr_we` and `lr_we` are 0.
- R2: Each cycle with `in_valid` high gives exactly one cycle with `out_valid` high, one clock later. Cycles without `in_valid` give `out_valid`, `ctr_we` and `lr_we` low.
- R3: Immediate kinds (codes 0 and 1) form an offset by sign-extending the displacement with two zero bits appended. Code 0 uses all 24 bits of `disp`; code 1 uses `disp[13:0]`. With `aa` = 1 the target is that offset. With `aa` = 0 the target is `cia` plus the offset. Code 0 is always taken.
- R4: For any kind code 0..4 with `lk` = 1, `lr_we` is 1 and `lr_wdata` is `cia`+4, whether or not the branch is taken.
- R5: Kinds 1, 2 and 4 with `bo[2]` = 0 assert `ctr_we`, with `ctr_wdata` = `ctr_in`-1 over all 64 bits. With `bo[2]` = 1 they leave `ctr_we` low.
- R6: For kinds 1, 2 and 4, the count test passes when `bo[2]` = 1. Otherwise it passes when (decremented count is nonzero) XOR `bo[1]`. So `bo[1]` = 0 branches on nonzero and `bo[1]` = 1 branches on zero.
- R7: With `mode64` = 0, the zero test of the decremented count looks only at its bits 31:0. With `mode64` = 1 it looks at all 64 bits.
- R8: The condition test passes when `bo[4]` = 1. Otherwise it passes when `cr[31-bi]` equals `bo[3]`; `bi` = 0 selects the most significant bit of `cr`. Kinds 1..4 are taken only when every test that applies to them passes.
- R9: Kind 2 targets `lr_in` and kind 4 targets `tar_in`, each with bits 1:0 cleared. Kind 2 uses the link value from before its own write-back.
- R10: Kind 3 applies only the condition test and never asserts `ctr_we`. Its target is `ctr_in` with bits 1:0 cleared.
- R11: A branch that is not taken gives `nia` = `cia`+4.
- R12: With `mode64` = 0, bits 63:32 of `nia` and `lr_wdata` are 0.
- R13: Kind codes 5..7 are never taken, assert neither write enable, and give `nia` = `cia`+4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A branch is offered this cycle |
| kind | input | 3 | Branch kind code 0..4 |
| aa | input | 1 | Absolute-address flag for immediate kinds |
| lk | input | 1 | Write link register with return address |
| bo | input | 5 | Branch options: [4] skip condition test, [3] required condition bit, [2] skip count (no decrement), [1] branch on zero count |
| bi | input | 5 | Selects condition bit `cr[31-bi]` |
| disp | input | 24 | Word displacement (code 1 uses bits 13:0) |
| cr | input | 32 | Condition register |
| ctr_in | input | 64 | Current count register |
| lr_in | input | 64 | Current link register |
| tar_in | input | 64 | Current target-address register |
| cia | input | 64 | Current instruction address |
| mode64 | input | 1 | 1: 64-bit mode, 0: 32-bit mode |
| out_valid | output | 1 | Result of the previous cycle's branch |
| taken | output | 1 | Branch taken |
| nia | output | 64 | Next instruction address |
| ctr_we | output | 1 | Count register write enable |
| ctr_wdata | output | 64 | New count register value |
| lr_we | output | 1 | Link register write enable |
| lr_wdata | output | 64 | New link register value |

## Verification
A decrementing, linking branch to the link register makes three things land in one result cycle. The count write-back, the link write-back, and a target read from the link register all appear together. The bench issues such a branch with the incoming link value differing from `cia`+4. It then requires `nia` to follow the old link value, while `lr_wdata` carries the return address and `ctr_wdata` the decremented count. Back-to-back issue of such branches, with the count crossing zero, additionally checks that each result pairs with its own inputs.

// File: rtl/br_resolve.sv
module br_resolve #(
  parameter int LIW = 24,
  parameter int BDW = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [2:0]        kind,
  input  logic              aa,
  input  logic              lk,
  input  logic [4:0]        bo,
  input  logic [4:0]        bi,
  input  logic [LIW-1:0]    disp,
  input  logic [31:0]       cr,
  input  logic [63:0]       ctr_in,
  input  logic [63:0]       lr_in,
  input  logic [63:0]       tar_in,
  input  logic [63:0]       cia,
  input  logic              mode64,
  output logic              out_valid,
  output logic              taken,
  output logic [63:0]       nia,
  output logic              ctr_we,
  output logic [63:0]       ctr_wdata,
  output logic              lr_we,
  output logic [63:0]       lr_wdata
);
  localparam int AW = 64;
  localparam logic [2:0] K_B = 3'd0, K_BC = 3'd1, K_BLR = 3'd2, K_BCTR = 3'd3, K_BTAR = 3'd4;

  logic [AW-1:0] mask, seq, ctr_m1, off, tgt;
  logic known, uses_ctr, dec, ctr_nz, ctr_ok, cond_ok, go;

  assign mask     = mode64 ? {AW{1'b1}} : {{(AW-32){1'b0}}, {32{1'b1}}};
  assign seq      = (cia + AW'(4)) & mask;
  assign known    = kind <= K_BTAR;
  assign uses_ctr = (kind == K_BC) || (kind == K_BLR) || (kind == K_BTAR);
  assign dec      = uses_ctr && !bo[2];
  assign ctr_m1   = ctr_in - AW'(1);
  assign ctr_nz   = mode64 ? |ctr_m1 : |ctr_m1[31:0];
  assign ctr_ok   = !uses_ctr || bo[2] || (ctr_nz ^ bo[1]);
  assign cond_ok  = bo[4] || (cr[~bi] == bo[3]);

  always_comb begin
    off = (kind == K_B) ? {{(AW-LIW-2){disp[LIW-1]}}, disp, 2'b00}
                        : {{(AW-BDW-2){disp[BDW-1]}}, disp[BDW-1:0], 2'b00};
    go  = 1'b0;
    tgt = seq;
    case (kind)
      K_B:    begin go = 1'b1;               tgt = aa ? off : cia + off; end
      K_BC:   begin go = ctr_ok && cond_ok;  tgt = aa ? off : cia + off; end
      K_BLR:  begin go = ctr_ok && cond_ok;  tgt = {lr_in[AW-1:2], 2'b00}; end
      K_BCTR: begin go = cond_ok;            tgt = {ctr_in[AW-1:2], 2'b00}; end
      K_BTAR: begin go = ctr_ok && cond_ok;  tgt = {tar_in[AW-1:2], 2'b00}; end
      default: begin go = 1'b0;              tgt = seq; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      taken     <= 1'b0;
      nia       <= '0;
      ctr_we    <= 1'b0;
      ctr_wdata <= '0;
      lr_we     <= 1'b0;
      lr_wdata  <= '0;
    end else begin
      out_valid <= in_valid;
      taken     <= in_valid && go;
      nia       <= go ? (tgt & mask) : seq;
      ctr_we    <= in_valid && dec;
      ctr_wdata <= ctr_m1;
      lr_we     <= in_valid && known && lk;
      lr_wdata  <= seq;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (!ctr_we && !lr_we && !taken)); // R2
  AST_LINK_WRITE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(lk && kind <= K_BTAR)) |-> (lr_we && lr_wdata[1:0] == $past(cia[1:0]) + 2'd0)); // R4
  AST_CTR_STEP: assert property (@(posedge clk) disable iff (rst)
    ctr_we |-> (ctr_wdata == $past(ctr_in) - 64'd1)); // R5
  AST_CNT_FORM_NO_DEC: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(kind) == K_BCTR) |-> !ctr_we); // R10
  AST_FALL_THROUGH: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !taken) |-> (nia == (($past(cia) + 64'd4) &
      ($past(mode64) ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF)))); // R11
  AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !$past(mode64)) |-> (nia[63:32] == 32'd0 && lr_wdata[63:32] == 32'd0)); // R12
  AST_BAD_KIND: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(kind) > K_BTAR) |-> (!taken && !ctr_we && !lr_we)); // R13
endmodule

// File: tb/br_resolve_tb.sv
module br_resolve_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [2:0] kind = '0;
  logic aa = 1'b0, lk = 1'b0, mode64 = 1'b1;
  logic [4:0] bo = '0, bi = '0;
  logic [23:0] disp = '0;
  logic [31:0] cr = '0;
  logic [63:0] ctr_in = '0, lr_in = '0, tar_in = '0, cia = '0;
  logic out_valid, taken, ctr_we, lr_we;
  logic [63:0] nia, ctr_wdata, lr_wdata;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  typedef struct {
    logic taken; logic [63:0] nia;
    logic ctr_we; logic [63:0] ctr_wdata;
    logic lr_we; logic [63:0] lr_wdata;
    string tag;
  } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  br_resolve u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .kind(kind), .aa(aa), .lk(lk),
    .bo(bo), .bi(bi), .disp(disp), .cr(cr), .ctr_in(ctr_in), .lr_in(lr_in),
    .tar_in(tar_in), .cia(cia), .mode64(mode64), .out_valid(out_valid),
    .taken(taken), .nia(nia), .ctr_we(ctr_we), .ctr_wdata(ctr_wdata),
    .lr_we(lr_we), .lr_wdata(lr_wdata)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  function automatic exp_t model(input string tag);
    exp_t e;
    logic [63:0] m, seq, off, dm1, tgt;
    logic uc, nz, cok, cdok, go;
    m   = mode64 ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
    seq = (cia + 64'd4) & m;
    uc  = (kind == 3'd1) || (kind == 3'd2) || (kind == 3'd4);
    dm1 = ctr_in - 64'd1;
    nz  = mode64 ? (dm1 != 0) : (dm1[31:0] != 0);
    cok = !uses_ok(uc) || bo[2] || (nz != bo[1]);
    cdok = bo[4] || (cr[31 - int'(bi)] == bo[3]);
    off = (kind == 3'd0) ? {{38{disp[23]}}, disp, 2'b00} : {{48{disp[13]}}, disp[13:0], 2'b00};
    go = 1'b0; tgt = seq;
    case (kind)
      3'd0: begin go = 1'b1; tgt = aa ? off : cia + off; end
      3'd1: begin go = cok && cdok; tgt = aa ? off : cia + off; end
      3'd2: begin go = cok && cdok; tgt = lr_in & ~64'd3; end
      3'd3: begin go = cdok; tgt = ctr_in & ~64'd3; end
      3'd4: begin go = cok && cdok; tgt = tar_in & ~64'd3; end
      default: go = 1'b0;
    endcase
    e.taken = go;
    e.nia = go ? (tgt & m) : seq;
    e.ctr_we = uc && !bo[2];
    e.ctr_wdata = dm1;
    e.lr_we = (kind <= 3'd4) && lk;
    e.lr_wdata = seq;
    e.tag = tag;
    return e;
  endfunction

  function automatic logic uses_ok(input logic u);
    return u;
  endfunction

  task automatic issue(input logic [2:0] k, input logic a, input logic l,
                       input logic [4:0] o, input logic [4:0] b, input logic [23:0] d,
                       input logic [31:0] c, input logic [63:0] ct, input logic [63:0] lr,
                       input logic [63:0] ta, input logic [63:0] pc, input logic m64,
                       input string tag);
    @(negedge clk);
    kind = k; aa = a; lk = l; bo = o; bi = b; disp = d; cr = c;
    ctr_in = ct; lr_in = lr; tar_in = ta; cia = pc; mode64 = m64; in_valid = 1'b1;
    sb.push_back(model(tag));
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(negedge clk); in_valid = 1'b0; end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      if (out_valid) begin
        if (sb.size() == 0) chk(1'b0, "R2", "unexpected out_valid", 64'd1, 64'd0);
        else begin
          exp_t e;
          e = sb.pop_front();
          chk(taken === e.taken, e.tag, "taken", 64'(taken), 64'(e.taken));
          chk(nia === e.nia, e.tag, "nia", nia, e.nia);
          chk(ctr_we === e.ctr_we, e.tag, "ctr_we", 64'(ctr_we), 64'(e.ctr_we));
          if (e.ctr_we) chk(ctr_wdata === e.ctr_wdata, e.tag, "ctr_wdata", ctr_wdata, e.ctr_wdata);
          chk(lr_we === e.lr_we, e.tag, "lr_we", 64'(lr_we), 64'(e.lr_we));
          if (e.lr_we) chk(lr_wdata === e.lr_wdata, e.tag, "lr_wdata", lr_wdata, e.lr_wdata);
        end
      end else
        chk(!ctr_we && !lr_we, "R2", "idle write enables", {62'd0, ctr_we, lr_we}, 64'd0);
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    in_valid = 1'b1; kind = 3'd0; lk = 1'b1;
    repeat (3) @(negedge clk);
    chk(!out_valid && !taken && !ctr_we && !lr_we, "R1", "reset outputs",
        {60'd0, out_valid, taken, ctr_we, lr_we}, 64'd0);
    in_valid = 1'b0; lk = 1'b0;
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk(!out_valid && !taken && !ctr_we && !lr_we, "R1", "after reset",
        {60'd0, out_valid, taken, ctr_we, lr_we}, 64'd0);
    // R3 immediate forms
    issue(3'd0, 1'b0, 1'b0, 5'd0, 5'd0, 24'hFFFFF0, 0, 64'd9, 0, 0, 64'h1000, 1'b1, "R3");
    issue(3'd0, 1'b1, 1'b1, 5'd0, 5'd0, 24'h000123, 0, 64'd9, 0, 0, 64'h2000, 1'b1, "R3_R4");
    issue(3'd1, 1'b0, 1'b0, 5'b10100, 5'd0, 24'h002001, 0, 64'd9, 0, 0, 64'h8000, 1'b1, "R3");
    issue(3'd1, 1'b1, 1'b0, 5'b10100, 5'd0, 24'hFF0010, 0, 64'd9, 0, 0, 64'h8000, 1'b1, "R3");
    idle(2);
    // R5 R6 count test
    issue(3'd1, 1'b0, 1'b0, 5'b10000, 5'd0, 24'h10, 0, 64'd5, 0, 0, 64'h300, 1'b1, "R5_R6");
    issue(3'd1, 1'b0, 1'b0, 5'b10000, 5'd0, 24'h10, 0, 64'd1, 0, 0, 64'h300, 1'b1, "R6");
    issue(3'd1, 1'b0, 1'b0, 5'b10010, 5'd0, 24'h10, 0, 64'd1, 0, 0, 64'h300, 1'b1, "R6");
    issue(3'd1, 1'b0, 1'b0, 5'b10010, 5'd0, 24'h10, 0, 64'd0, 0, 0, 64'h300, 1'b1, "R5_R6");
    // R7 narrow zero test
    issue(3'd1, 1'b0, 1'b0, 5'b10000, 5'd0, 24'h10, 0, 64'h1_0000_0001, 0, 0, 64'h300, 1'b0, "R7");
    issue(3'd1, 1'b0, 1'b0, 5'b10000, 5'd0, 24'h10, 0, 64'h1_0000_0001, 0, 0, 64'h300, 1'b1, "R7");
    // R8 condition test
    issue(3'd1, 1'b0, 1'b0, 5'b01100, 5'd0, 24'h10, 32'h8000_0000, 0, 0, 0, 64'h400, 1'b1, "R8");
    issue(3'd1, 1'b0, 1'b0, 5'b01100, 5'd31, 24'h10, 32'h8000_0000, 0, 0, 0, 64'h400, 1'b1, "R8");
    issue(3'd1, 1'b0, 1'b0, 5'b00100, 5'd31, 24'h10, 32'h8000_0000, 0, 0, 0, 64'h400, 1'b1, "R8");
    issue(3'd1, 1'b0, 1'b0, 5'b00000, 5'd3, 24'h10, 32'h1000_0000, 64'd7, 0, 0, 64'h400, 1'b1, "R8");
    idle(1);
    // R9 link form, same-cycle decrement and link write, back to back
    issue(3'd2, 1'b0, 1'b1, 5'b10000, 5'd0, 0, 0, 64'd3, 64'hABCD_0007, 0, 64'h500, 1'b1, "R9");
    issue(3'd2, 1'b0, 1'b1, 5'b10000, 5'd0, 0, 0, 64'd2, 64'h504, 0, 64'h600, 1'b1, "R9");
    issue(3'd2, 1'b0, 1'b1, 5'b10000, 5'd0, 0, 0, 64'd1, 64'h604, 0, 64'h700, 1'b1, "R9_R11");
    issue(3'd4, 1'b0, 1'b0, 5'b10100, 5'd0, 0, 0, 64'd1, 0, 64'h9999_0003, 64'h800, 1'b1, "R9");
    // R10 count form
    issue(3'd3, 1'b0, 1'b0, 5'b10000, 5'd0, 0, 0, 64'h4443, 0, 0, 64'h900, 1'b1, "R10");
    issue(3'd3, 1'b0, 1'b1, 5'b01100, 5'd2, 0, 32'h0, 64'h4443, 0, 0, 64'h900, 1'b1, "R10_R11");
    // R12 narrow mode addresses
    issue(3'd0, 1'b0, 1'b1, 5'd0, 5'd0, 24'h40, 0, 0, 0, 0, 64'hFFFF_0000_FFFF_FFF0, 1'b0, "R12");
    issue(3'd4, 1'b0, 1'b0, 5'b10100, 5'd0, 0, 0, 0, 0, 64'hDEAD_0000_1234_5678, 64'h10, 1'b0, "R12");
    // R13 undefined kinds
    issue(3'd5, 1'b1, 1'b1, 5'b10000, 5'd0, 24'h40, 0, 64'd5, 0, 0, 64'hC00, 1'b1, "R13");
    issue(3'd7, 1'b0, 1'b1, 5'b10100, 5'd0, 24'h40, 0, 64'd5, 0, 0, 64'hC00, 1'b1, "R13");
    idle(4);
    chk(sb.size() == 0, "R2", "pending results", 64'(sb.size()), 64'd0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule